// File: doc/BRIEF.md
# Misaligned Memory Access Splitter

The block accepts one load or store request at a time and turns it into a sequence of naturally aligned sub-operations on a valid/ready output. A request has a 64-bit address, a size of 1, 2, 4, 8 or 16 bytes given as a base-two logarithm, and up to 16 bytes of write data. Four run-time controls set its behaviour. The first decides whether misaligned requests are legal. The second is an aligned-window exponent E: an access that stays inside one 2^E-byte window goes out whole. The third chooses largest-chunk or single-byte splitting. The fourth chooses ascending or descending issue order.

The alignment check and the window/split decision both use the request address as given. Each outgoing operation is then checked against a 2-bit region attribute supplied for that operation's address. A misaligned operation in a faulting region is not issued, and the request ends with that exception.

Every sub-operation carries its byte offset into the original access. Its write data is presented shifted down so that byte lane 0 holds the first byte of the piece. Each request ends with a one-cycle done pulse that carries an exception code.

Top module: `mis_split`

## Requirements
- R1: With `cfg_mis_en_i` low, a request whose address is not a multiple of its size issues no sub-operation. The cycle after acceptance, `done_o` pulses with `done_exc_o` = 1 (misaligned address).
- R2: If every byte of the access has the same address bits above bit E (E = `cfg_win_exp_i`, 0..11), exactly one operation is issued. It has the request's address and size, and offset 0.
- R3: In chunk mode (`cfg_byte_mode_i` low), an access that leaves its 2^E window is split. Each piece has size 2^k, where k is the largest value that satisfies all four conditions: k ≤ min(E,4); 2^k ≤ bytes remaining; the piece's issuing-side edge is a multiple of 2^k; k ≤ 4.
- R4: In byte mode (`cfg_byte_mode_i` high), every piece of a split access is one byte (`op_size_o` = 0).
- R5: With `cfg_desc_i` low, pieces go out from the lowest address up. With it high, pieces go out from the highest address down, and each piece is sized from its upper edge.
- R6: An operation whose address is not a multiple of its size is checked against `op_attr_i`. Attribute 0 issues it. Attribute 1 withholds it and ends the request with `done_exc_o` = 2 (access fault). Attribute 2 or 3 withholds it and ends the request with `done_exc_o` = 3 (alignment fault). The remaining pieces are dropped.
- R7: `op_offset_o` equals the piece address minus the request address. `op_wdata_o` equals the request write data shifted right by 8·offset bits.
- R8: `req_ready_o` is high only when no request is in progress.
- R9: While `op_valid_o` is high and `op_ready_i` is low, the presented operation holds.
- R10: After the last piece is accepted, `done_o` pulses for one cycle with `done_exc_o` = 0, and the block is ready again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request taken |
| req_addr_i | input | 64 | Request address |
| req_size_i | input | 3 | log2 of request size, 0..4 |
| req_wdata_i | input | 128 | Write data, byte 0 at the request address |
| cfg_mis_en_i | input | 1 | Misaligned requests permitted |
| cfg_win_exp_i | input | 4 | Aligned-window exponent E, 0..11 |
| cfg_byte_mode_i | input | 1 | Split into single bytes |
| cfg_desc_i | input | 1 | Issue pieces highest address first |
| op_valid_o | output | 1 | Sub-operation present |
| op_ready_i | input | 1 | Sub-operation taken |
| op_addr_o | output | 64 | Sub-operation address |
| op_size_o | output | 3 | log2 of sub-operation size |
| op_offset_o | output | 4 | Byte offset of the piece within the request |
| op_wdata_o | output | 128 | Write data steered to lane 0 |
| op_attr_i | input | 2 | Region attribute for `op_addr_o` |
| done_o | output | 1 | Request finished, one-cycle pulse |
| done_exc_o | output | 2 | 0 none, 1 misaligned, 2 access fault, 3 alignment fault |

## Verification
The assertions rely on three assumptions about the inputs:
- `req_size_i` never exceeds 4.
- The four controls stay constant from acceptance to the done pulse.
- `op_attr_i` depends only on the presented operation, so it is steady while an operation is held.

The stimulus follows all three. For each request it sets the controls and a fixed attribute value before presenting the request, and it changes them only after done. Sizes are kept in range, window exponents are drawn from the legal span, and addresses include a base near the top of the address space so that the exclusive end address wraps. The bench throttles `op_ready_i` in a fixed pattern, so stalls occur in every sweep.

// File: rtl/mis_split_pkg.sv
package mis_split_pkg;
  typedef enum logic [1:0] {
    EXC_NONE     = 2'd0,
    EXC_MISALIGN = 2'd1,
    EXC_ACCESS   = 2'd2,
    EXC_ALIGN    = 2'd3
  } exc_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DONE  = 2'd2
  } st_e;
endpackage

// File: rtl/mis_split_decode.sv
module mis_split_decode #(
  parameter int ADDR_W = 64,
  parameter int SZ_W   = 3,
  parameter int EXP_W  = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SZ_W-1:0]   size_i,
  input  logic [EXP_W-1:0]  win_exp_i,
  output logic              mis_o,
  output logic              in_win_o
);
  logic [ADDR_W-1:0] low_mask, last_addr;

  always_comb begin
    low_mask  = (ADDR_W'(1) << size_i) - ADDR_W'(1);
    last_addr = addr_i + low_mask;
    mis_o     = |(addr_i & low_mask);
    in_win_o  = ((addr_i ^ last_addr) >> win_exp_i) == '0;
  end
endmodule

// File: rtl/mis_split_piece.sv
module mis_split_piece #(
  parameter int ADDR_W  = 64,
  parameter int MAX_LOG = 4,
  parameter int EXP_W   = 4,
  localparam int SZ_W   = $clog2(MAX_LOG + 1),
  localparam int REM_W  = MAX_LOG + 1
) (
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic [REM_W-1:0]  rem_i,
  input  logic [EXP_W-1:0]  win_exp_i,
  input  logic              byte_mode_i,
  input  logic              desc_i,
  output logic [SZ_W-1:0]   p_log_o,
  output logic [REM_W-1:0]  p_bytes_o,
  output logic [ADDR_W-1:0] p_addr_o
);
  logic [ADDR_W-1:0] edge_addr;
  logic [EXP_W-1:0]  cap;

  always_comb begin
    edge_addr = desc_i ? hi_i : lo_i;
    cap       = (win_exp_i > EXP_W'(MAX_LOG)) ? EXP_W'(MAX_LOG) : win_exp_i;
    p_log_o   = '0;
    // conditions shrink monotonically with k, so the last hit is the largest
    for (int k = 1; k <= MAX_LOG; k++) begin
      if (!byte_mode_i && EXP_W'(k) <= cap && (REM_W'(1) << k) <= rem_i &&
          (edge_addr & ((ADDR_W'(1) << k) - ADDR_W'(1))) == '0)
        p_log_o = SZ_W'(k);
    end
    p_bytes_o = REM_W'(1) << p_log_o;
    p_addr_o  = desc_i ? hi_i - ADDR_W'(p_bytes_o) : lo_i;
  end
endmodule

// File: rtl/mis_split_lane.sv
module mis_split_lane #(
  parameter int DATA_W = 128,
  parameter int OFS_W  = 4
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [DATA_W-1:0] data_o
);
  assign data_o = data_i >> {ofs_i, 3'b000};
endmodule

// File: rtl/mis_split.sv
module mis_split #(
  parameter int ADDR_W  = 64,
  parameter int MAX_LOG = 4,
  parameter int EXP_W   = 4,
  localparam int SZ_W   = $clog2(MAX_LOG + 1),
  localparam int REM_W  = MAX_LOG + 1,
  localparam int OFS_W  = MAX_LOG,
  localparam int DATA_W = 8 << MAX_LOG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [SZ_W-1:0]   req_size_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              cfg_mis_en_i,
  input  logic [EXP_W-1:0]  cfg_win_exp_i,
  input  logic              cfg_byte_mode_i,
  input  logic              cfg_desc_i,
  output logic              op_valid_o,
  input  logic              op_ready_i,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [SZ_W-1:0]   op_size_o,
  output logic [OFS_W-1:0]  op_offset_o,
  output logic [DATA_W-1:0] op_wdata_o,
  input  logic [1:0]        op_attr_i,
  output logic              done_o,
  output logic [1:0]        done_exc_o
);
  import mis_split_pkg::*;

  st_e               st_q;
  exc_e              exc_q;
  logic [ADDR_W-1:0] lo_q, hi_q;
  logic [REM_W-1:0]  rem_q;
  logic              single_q;
  logic [SZ_W-1:0]   full_log_q;
  logic [OFS_W-1:0]  base_ofs_q;
  logic [DATA_W-1:0] wdata_q;

  logic              req_mis, req_in_win;
  logic [SZ_W-1:0]   p_log;
  logic [REM_W-1:0]  p_bytes;
  logic [ADDR_W-1:0] p_addr;
  logic              op_mis, fault, last_piece;
  logic [REM_W-1:0]  req_bytes;

  mis_split_decode #(.ADDR_W(ADDR_W), .SZ_W(SZ_W), .EXP_W(EXP_W)) u_decode (
    .addr_i   (req_addr_i),
    .size_i   (req_size_i),
    .win_exp_i(cfg_win_exp_i),
    .mis_o    (req_mis),
    .in_win_o (req_in_win)
  );

  mis_split_piece #(.ADDR_W(ADDR_W), .MAX_LOG(MAX_LOG), .EXP_W(EXP_W)) u_piece (
    .lo_i       (lo_q),
    .hi_i       (hi_q),
    .rem_i      (rem_q),
    .win_exp_i  (cfg_win_exp_i),
    .byte_mode_i(cfg_byte_mode_i),
    .desc_i     (cfg_desc_i),
    .p_log_o    (p_log),
    .p_bytes_o  (p_bytes),
    .p_addr_o   (p_addr)
  );

  mis_split_lane #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_lane (
    .data_i(wdata_q),
    .ofs_i (op_offset_o),
    .data_o(op_wdata_o)
  );

  always_comb begin
    req_bytes   = REM_W'(1) << req_size_i;
    op_addr_o   = single_q ? lo_q : p_addr;
    op_size_o   = single_q ? full_log_q : p_log;
    op_offset_o = op_addr_o[OFS_W-1:0] - base_ofs_q;
    op_mis      = |(op_addr_o & ((ADDR_W'(1) << op_size_o) - ADDR_W'(1)));
    fault       = (st_q == ST_ISSUE) && op_mis && (op_attr_i != 2'd0);
    op_valid_o  = (st_q == ST_ISSUE) && !fault;
    last_piece  = single_q || (rem_q == p_bytes);
    req_ready_o = (st_q == ST_IDLE);
    done_o      = (st_q == ST_DONE);
    done_exc_o  = exc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      exc_q      <= EXC_NONE;
      lo_q       <= '0;
      hi_q       <= '0;
      rem_q      <= '0;
      single_q   <= 1'b0;
      full_log_q <= '0;
      base_ofs_q <= '0;
      wdata_q    <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            if (!cfg_mis_en_i && req_mis) begin
              st_q  <= ST_DONE;
              exc_q <= EXC_MISALIGN;
            end else begin
              st_q       <= ST_ISSUE;
              exc_q      <= EXC_NONE;
              lo_q       <= req_addr_i;
              hi_q       <= req_addr_i + ADDR_W'(req_bytes);
              rem_q      <= req_bytes;
              single_q   <= req_in_win;
              full_log_q <= req_size_i;
              base_ofs_q <= req_addr_i[OFS_W-1:0];
              wdata_q    <= req_wdata_i;
            end
          end
        end
        ST_ISSUE: begin
          if (fault) begin
            st_q  <= ST_DONE;
            exc_q <= (op_attr_i == 2'd1) ? EXC_ACCESS : EXC_ALIGN;
          end else if (op_ready_i) begin
            if (last_piece) begin
              st_q <= ST_DONE;
            end else begin
              rem_q <= rem_q - p_bytes;
              if (cfg_desc_i) hi_q <= p_addr;
              else            lo_q <= lo_q + ADDR_W'(p_bytes);
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mis_split_chk.sv
module mis_split_chk #(
  parameter int ADDR_W = 64,
  parameter int SZ_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [SZ_W-1:0]   req_size_i,
  input logic              cfg_mis_en_i,
  input logic              op_valid_o,
  input logic              op_ready_i,
  input logic [ADDR_W-1:0] op_addr_o,
  input logic [SZ_W-1:0]   op_size_o,
  input logic [1:0]        op_attr_i,
  input logic              done_o,
  input logic [1:0]        done_exc_o
);
  logic req_off, op_off;
  assign req_off = |(req_addr_i & ((ADDR_W'(1) << req_size_i) - ADDR_W'(1)));
  assign op_off  = |(op_addr_o & ((ADDR_W'(1) << op_size_o) - ADDR_W'(1)));

  a_r1_misalign_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !cfg_mis_en_i && req_off)
      |=> (done_o && done_exc_o == 2'd1 && !op_valid_o));

  a_r6_fault_withheld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_o |-> !(op_off && op_attr_i != 2'd0));

  a_r8_busy_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o || done_o) |-> !req_ready_o);

  a_r9_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && !op_ready_i)
      |=> (op_valid_o && $stable(op_addr_o) && $stable(op_size_o)));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o && !op_valid_o));
endmodule

bind mis_split mis_split_chk #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_chk (.*);

// File: tb/mis_split_test.sv
module mis_split_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [63:0]  req_addr_i = '0;
  logic [2:0]   req_size_i = '0;
  logic [127:0] req_wdata_i = '0;
  logic         cfg_mis_en_i = 1'b0;
  logic [3:0]   cfg_win_exp_i = '0;
  logic         cfg_byte_mode_i = 1'b0;
  logic         cfg_desc_i = 1'b0;
  logic         op_valid_o;
  logic         op_ready_i = 1'b0;
  logic [63:0]  op_addr_o;
  logic [2:0]   op_size_o;
  logic [3:0]   op_offset_o;
  logic [127:0] op_wdata_o;
  logic [1:0]   op_attr_i = '0;
  logic         done_o;
  logic [1:0]   done_exc_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [63:0] e_addr [16];
  int          e_log  [16];
  int          e_n;
  int          e_exc;
  bit          e_single;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  mis_split uut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic build_expect(input logic [63:0] a, input int slog, input bit mis_en,
                              input int e, input bit bmode, input bit desc, input int attr);
    logic [63:0] sz, last, lo, hi, edge_a;
    int rem, cap, k;
    sz = 64'(1) << slog;
    e_n = 0; e_exc = 0; e_single = 0;
    if (!mis_en && (a % sz) != 0) begin
      e_exc = 1;
      return;
    end
    last = a + sz - 1;
    if ((a >> e) == (last >> e)) begin
      e_single = 1;
      if ((a % sz) != 0 && attr != 0) e_exc = (attr == 1) ? 2 : 3;
      else begin e_addr[0] = a; e_log[0] = slog; e_n = 1; end
      return;
    end
    lo = a; hi = a + sz; rem = int'(sz);
    cap = (e > 4) ? 4 : e;
    while (rem > 0) begin
      edge_a = desc ? hi : lo;
      k = 0;
      if (!bmode)
        for (int kk = 1; kk <= 4; kk++)
          if (kk <= cap && (1 << kk) <= rem && (edge_a % (64'(1) << kk)) == 0) k = kk;
      if (desc) begin hi = hi - (64'(1) << k); e_addr[e_n] = hi; end
      else begin e_addr[e_n] = lo; lo = lo + (64'(1) << k); end
      e_log[e_n] = k;
      e_n++;
      rem -= (1 << k);
    end
  endtask

  task automatic run_req(input logic [63:0] a, input int slog, input bit mis_en,
                         input int e, input bit bmode, input bit desc, input int attr,
                         input logic [7:0] seed);
    int idx;
    bit fin, acc;
    string tag_a, tag_s, tag_d;
    logic [127:0] wd;
    logic [63:0] ofs;
    for (int b = 0; b < 16; b++) wd[b*8 +: 8] = 8'(b * 17) ^ seed;
    build_expect(a, slog, mis_en, e, bmode, desc, attr);
    tag_s = e_single ? "R2" : (bmode ? "R4" : "R3");
    tag_a = desc ? "R5" : tag_s;
    tag_d = (e_exc == 1) ? "R1" : ((e_exc != 0) ? "R6" : "R10");
    @(negedge clk_i);
    req_addr_i = a; req_size_i = 3'(slog); req_wdata_i = wd;
    cfg_mis_en_i = mis_en; cfg_win_exp_i = 4'(e); cfg_byte_mode_i = bmode;
    cfg_desc_i = desc; op_attr_i = 2'(attr);
    req_valid_i = 1'b1;
    chk(req_ready_o == 1'b1, "R8", "ready when idle", 128'(req_ready_o), 1);
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    idx = 0; fin = 0;
    for (int t = 0; t < 60 && !fin; t++) begin
      acc = 0;
      chk(req_ready_o == 1'b0, "R8", "busy not ready", 128'(req_ready_o), 0);
      if (done_o) begin
        chk(int'(done_exc_o) == e_exc, tag_d, "exception", 128'(done_exc_o), 128'(e_exc));
        chk(idx == e_n, tag_d, "piece count at done", 128'(idx), 128'(e_n));
        chk(!op_valid_o, "R10", "no op at done", 128'(op_valid_o), 0);
        fin = 1;
      end else if (op_valid_o) begin
        if (idx >= e_n) begin
          chk(0, tag_d, "extra op", 128'(op_addr_o), 0);
          fin = 1;
        end else begin
          ofs = e_addr[idx] - a;
          chk(op_addr_o == e_addr[idx], tag_a, "address", 128'(op_addr_o), 128'(e_addr[idx]));
          chk(int'(op_size_o) == e_log[idx], tag_s, "size", 128'(op_size_o), 128'(e_log[idx]));
          chk(op_offset_o == ofs[3:0], "R7", "offset", 128'(op_offset_o), 128'(ofs[3:0]));
          chk(op_wdata_o == (wd >> (8 * ofs[3:0])), "R7", "steered data",
              op_wdata_o, wd >> (8 * ofs[3:0]));
          op_ready_i = (cyc % 3) != 2;
          acc = op_ready_i;
        end
      end
      if (!fin) begin
        @(posedge clk_i);
        if (acc) idx++;
        @(negedge clk_i);
        op_ready_i = 1'b0;
      end
    end
    if (!fin) chk(0, tag_d, "no done pulse", 0, 1);
  endtask

  task automatic run_all();
    int es [5] = '{0, 2, 3, 4, 11};
    int n = 0;
    logic [63:0] base;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(req_ready_o == 1'b1, "R8", "reset ready", 128'(req_ready_o), 1);
    chk(op_valid_o == 1'b0, "R10", "reset op_valid", 128'(op_valid_o), 0);
    chk(done_o == 1'b0, "R10", "reset done", 128'(done_o), 0);
    rst_ni = 1'b1;
    for (int s = 0; s <= 4; s++)
      for (int a = 0; a < 20; a++)
        for (int ei = 0; ei < 5; ei++)
          for (int m = 0; m < 8; m++) begin
            base = n[0] ? 64'hFFFF_FFFF_FFFF_FFE0 : 64'h0000_0000_8000_1000;
            run_req(base + 64'(a), s, m[0], es[ei], m[1], m[2], n % 3, 8'(n));
            n++;
          end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (WATCHDOG) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=<%0d cycles", WATCHDOG, WATCHDOG);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule